// File: doc/BRIEF.md
# Banked Interrupt Controller with Per-Source Clear Addresses

This block collects up to 48 interrupt request lines from the peripherals around a processor core. It presents them to software as three banks of 16 sources. Each bank has a read-only status register and a read/write enable register. Source `n` sits in bank `n/16` at bit `n%16`.

Two kinds of source exist. Event sources hold a sticky flag that a rising request sets. Software drops the flag by writing to that source's own clear address, and the data written there is ignored. Level sources show the live state of their request wire and have no clear address. A fixed class per source routes a few sources to a fast-interrupt line. Every other source drives the normal interrupt line.

Software reaches the block through a plain register bus with a one-cycle read latency. The two interrupt lines are registered and active high.

Top module: `banked_intc`

## Requirements
- R1: The status register of bank `b` is at address `0x0240 + b*0x1000`. Its bit `i` shows source `16*b+i`, zero-extended to 32 bits. Bits of unused sources (0, 2, 19–27, 30, 31, 33–47) always read 0.
- R2: The enable register of bank `b` is at address `0x0280 + b*0x1000`. It stores `bus_wdata[15:0]` and reads back the same value. A bit value of 1 enables its source. Writing 0 disables all sixteen sources of that bank.
- R3: Event sources are 1, 3, 4, 8, 9, 10, 11, 14, 15 and 16. For each of them, a request that is low at one clock edge and high at the next sets the status flag. The flag stays set after the request falls.
- R4: Each event source has its own clear address: 1→0x0600, 3→0x0640, 11→0x0680, 8→0x06C0, 9→0x0700, 10→0x0740, 14→0x0780, 4→0x07C0, 15→0x1600, 16→0x1700. A write of any data to that address clears the flag at the next edge.
- R5: When a rising request and a clear write for the same event source reach the same clock edge, the flag stays set.
- R6: Level sources are 5, 6, 7, 12, 13, 17, 18, 28, 29 and 32. Their status bits equal the current request input.
- R7: `irq_o` is asserted one cycle after any source outside the fast class has both its status bit and its enable bit set.
- R8: Sources 1, 3 and 32 form the fast class. They assert `fiq_o` one cycle after status AND enable is set, and they never assert `irq_o`.
- R9: Reads of undefined addresses return 0. Writes to undefined addresses or to status addresses change no state.
- R10: Reset clears all enable registers, all event flags, both interrupt outputs and the read data.
- R11: `bus_rdata` carries the addressed register in the cycle after `bus_rd`. It is 0 in every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 48 | Request line of each source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| irq_o | output | 1 | Normal interrupt, registered |
| fiq_o | output | 1 | Fast interrupt, registered |

## Verification
Assertions check three event-flag rules on every cycle: hold, clear, and edge-beats-clear. They also check that each enable write lands, that unused status bits stay zero, that both interrupt outputs follow status AND enable one cycle later, and that the idle read bus reads zero. Some behaviour only the bench scenarios can show. These are the full address map, data-independence of the clear writes, the silence of undefined and status-address writes, and the reset of state in the middle of a run. The bench covers them by reading registers back against its own model while random request, enable and clear traffic runs.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        K_UNUSED = 2'd0,
        K_LEVEL  = 2'd1,
        K_EVENT  = 2'd2
    } src_kind_e;

    function automatic logic has_clear(input int n);
        case (n)
            1, 3, 4, 8, 9, 10, 11, 14, 15, 16: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    function automatic logic is_level(input int n);
        case (n)
            5, 6, 7, 12, 13, 17, 18, 28, 29, 32: return 1'b1;
            default:                             return 1'b0;
        endcase
    endfunction

    function automatic logic is_fast(input int n);
        case (n)
            1, 3, 32: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic src_kind_e kind_of(input int n);
        if (has_clear(n))     return K_EVENT;
        else if (is_level(n)) return K_LEVEL;
        else                  return K_UNUSED;
    endfunction

    function automatic logic [15:0] clear_addr(input int n);
        case (n)
            1:       return 16'h0600;
            3:       return 16'h0640;
            11:      return 16'h0680;
            8:       return 16'h06C0;
            9:       return 16'h0700;
            10:      return 16'h0740;
            14:      return 16'h0780;
            4:       return 16'h07C0;
            15:      return 16'h1600;
            16:      return 16'h1700;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [15:0] stat_addr(input int b);
        return 16'(32'h0240 + b * 32'h1000);
    endfunction

    function automatic logic [15:0] mask_addr(input int b);
        return 16'(32'h0280 + b * 32'h1000);
    endfunction

endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
    import intc_pkg::*;
#(
    parameter src_kind_e KIND = K_UNUSED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic clr_i,
    output logic stat_o
);

    generate
        if (KIND == K_EVENT) begin : g_event
            logic prev_q;
            logic flag_q;
            logic rise;

            assign rise = req_i & ~prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    flag_q <= 1'b0;
                end else begin
                    prev_q <= req_i;
                    if (rise)       flag_q <= 1'b1;
                    else if (clr_i) flag_q <= 1'b0;
                end
            end

            assign stat_o = flag_q;

            // R3: a set flag survives any cycle without a clear
            a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q && !clr_i) |=> flag_q);

            // R4: a clear without a competing edge drops the flag
            a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i && !(req_i && !prev_q)) |=> !flag_q);

            // R5: a fresh edge wins over a simultaneous clear
            a_r5_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i && req_i && !prev_q) |=> flag_q);
        end else if (KIND == K_LEVEL) begin : g_level
            logic unused_lvl;
            assign unused_lvl = ^{clk, rst_n, clr_i};
            assign stat_o     = req_i;
        end else begin : g_none
            logic unused_nc;
            assign unused_nc = ^{clk, rst_n, clr_i, req_i};
            assign stat_o    = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
    parameter int               BANK_W    = 16,
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MASK_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] mask_o
);

    logic hit;
    assign hit = wr_i && (addr_i == MASK_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mask_o <= '0;
        else if (hit) mask_o <= wdata_i;
    end

    // R2: a write to this bank's enable address lands on the next edge
    a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == MASK_ADDR) |=> (mask_o == $past(wdata_i)));

endmodule

// File: rtl/banked_intc.sv
module banked_intc
    import intc_pkg::*;
#(
    parameter int NBANK  = 3,
    parameter int BANK_W = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NBANK*BANK_W-1:0] req_i,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    irq_o,
    output logic                    fiq_o
);

    localparam int NSRC = NBANK * BANK_W;

    logic [NSRC-1:0] status;
    logic [NSRC-1:0] mask_all;
    logic [NSRC-1:0] clr_hit;
    logic [NSRC-1:0] fast_sel;
    logic [NSRC-1:0] used_sel;
    logic [DATA_W-1:0] rd_next;
    logic unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:BANK_W];

    genvar s;
    generate
        for (s = 0; s < NSRC; s++) begin : g_src
            assign fast_sel[s] = is_fast(s);
            assign used_sel[s] = (kind_of(s) != K_UNUSED);
            assign clr_hit[s]  = bus_wr && has_clear(s) &&
                                 (bus_addr == ADDR_W'(clear_addr(s)));
            intc_src_cell #(.KIND(kind_of(s))) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_i  (req_i[s]),
                .clr_i  (clr_hit[s]),
                .stat_o (status[s])
            );
        end
    endgenerate

    genvar b;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            intc_mask_bank #(
                .BANK_W    (BANK_W),
                .ADDR_W    (ADDR_W),
                .MASK_ADDR (ADDR_W'(mask_addr(b)))
            ) u_mask (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_i    (bus_wr),
                .addr_i  (bus_addr),
                .wdata_i (bus_wdata[BANK_W-1:0]),
                .mask_o  (mask_all[b*BANK_W +: BANK_W])
            );
        end
    endgenerate

    always_comb begin
        rd_next = '0;
        for (int k = 0; k < NBANK; k++) begin
            if (bus_addr == ADDR_W'(stat_addr(k)))
                rd_next = DATA_W'(status[k*BANK_W +: BANK_W]);
            if (bus_addr == ADDR_W'(mask_addr(k)))
                rd_next = DATA_W'(mask_all[k*BANK_W +: BANK_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            irq_o     <= 1'b0;
            fiq_o     <= 1'b0;
        end else begin
            bus_rdata <= bus_rd ? rd_next : '0;
            irq_o     <= |(status & mask_all & ~fast_sel);
            fiq_o     <= |(status & mask_all & fast_sel);
        end
    end

    // R1: unused sources never show a status bit
    always_comb begin
        if (rst_n) begin
            a_r1_unused_zero: assert ((status & ~used_sel) == '0);
        end
    end

    // R7: an enabled normal-class pending source raises irq next cycle
    a_r7_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & mask_all & ~fast_sel)) |=> irq_o);

    // R8: an enabled fast-class pending source raises fiq next cycle
    a_r8_fiq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & mask_all & fast_sel)) |=> fiq_o);

    // R8: with nothing normal-class pending, irq stays low
    a_r8_fast_not_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask_all & ~fast_sel) == '0) |=> !irq_o);

    // R11: no read strobe means zero read data next cycle
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

// File: tb/sim_banked_intc.sv
module sim_banked_intc;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] req = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [47:0] m_lat = '0;
    logic [47:0] m_prev = '0;
    logic [15:0] m_mask [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_intc u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    function automatic bit tb_event(int n);
        return n inside {1, 3, 4, 8, 9, 10, 11, 14, 15, 16};
    endfunction
    function automatic bit tb_level(int n);
        return n inside {5, 6, 7, 12, 13, 17, 18, 28, 29, 32};
    endfunction
    function automatic bit tb_fast(int n);
        return n inside {1, 3, 32};
    endfunction
    function automatic logic [15:0] tb_clr(int n);
        case (n)
            1: return 16'h0600;  3: return 16'h0640;  11: return 16'h0680;
            8: return 16'h06C0;  9: return 16'h0700;  10: return 16'h0740;
            14: return 16'h0780; 4: return 16'h07C0;  15: return 16'h1600;
            16: return 16'h1700; default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [47:0] cur_status(logic [47:0] rq);
        logic [47:0] s = '0;
        for (int n = 0; n < 48; n++)
            s[n] = tb_event(n) ? m_lat[n] : (tb_level(n) ? rq[n] : 1'b0);
        return s;
    endfunction

    function automatic logic [31:0] exp_read(logic [15:0] a, logic [47:0] rq);
        logic [47:0] s = cur_status(rq);
        for (int b = 0; b < 3; b++) begin
            if (a == 16'(16'h0240 + b * 16'h1000)) return {16'h0, s[b*16 +: 16]};
            if (a == 16'(16'h0280 + b * 16'h1000)) return {16'h0, m_mask[b]};
        end
        return 32'h0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(logic [47:0] rq, logic w, logic r, logic [15:0] a,
                        logic [31:0] d, string tag);
        logic [47:0] s  = cur_status(rq);
        logic [47:0] mk = {m_mask[2], m_mask[1], m_mask[0]};
        logic [47:0] fs = '0;
        logic e_irq, e_fiq;
        logic [31:0] e_rd;
        for (int n = 0; n < 48; n++) fs[n] = tb_fast(n);
        e_irq = |(s & mk & ~fs);
        e_fiq = |(s & mk & fs);
        e_rd  = r ? exp_read(a, rq) : 32'h0;
        req = rq; wr = w; rd = r; addr = a; wdata = d;
        @(posedge clk);
        for (int n = 0; n < 48; n++) begin
            if (tb_event(n)) begin
                logic rise = rq[n] & ~m_prev[n];
                logic clr  = w && (a == tb_clr(n));
                m_lat[n] = rise | (m_lat[n] & ~clr);
            end
        end
        m_prev = rq;
        for (int b = 0; b < 3; b++)
            if (w && a == 16'(16'h0280 + b * 16'h1000)) m_mask[b] = d[15:0];
        @(negedge clk);
        chk("R7", {31'h0, irq}, {31'h0, e_irq});
        chk("R8", {31'h0, fiq}, {31'h0, e_fiq});
        chk(r ? tag : "R11", rdata, e_rd);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = '0; wr = 0; rd = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        m_lat = '0; m_prev = '0;
        for (int b = 0; b < 3; b++) m_mask[b] = '0;
        chk("R10", {29'h0, irq, fiq, |rdata}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_all(logic [47:0] rq, string tag);
        for (int b = 0; b < 3; b++) begin
            step(rq, 0, 1, 16'(16'h0240 + b * 16'h1000), 0, tag);
            step(rq, 0, 1, 16'(16'h0280 + b * 16'h1000), 0, tag);
        end
    endtask

    function automatic logic [15:0] pick_addr(int k);
        case (k % 16)
            0: return 16'h0240; 1: return 16'h0280; 2: return 16'h1240;
            3: return 16'h1280; 4: return 16'h2240; 5: return 16'h2280;
            6: return 16'h0600; 7: return 16'h0640; 8: return 16'h06C0;
            9: return 16'h0700; 10: return 16'h07C0; 11: return 16'h1600;
            12: return 16'h1700; 13: return 16'h0680; 14: return 16'h0300;
            default: return 16'h0780;
        endcase
    endfunction

    function automatic string tag_of(logic [15:0] a);
        if (a[7:0] == 8'h40) return "R1";
        if (a[7:0] == 8'h80) return "R2";
        return "R9";
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [47:0] rq;
        void'($urandom(32'h1D5C_0A17));
        for (int b = 0; b < 3; b++) m_mask[b] = '0;
        @(negedge clk);
        do_reset();
        read_all('0, "R10");

        // R2: enable every source, read back
        for (int b = 0; b < 3; b++)
            step('0, 1, 0, 16'(16'h0280 + b * 16'h1000), 32'hABCD_FFFF, "R2");
        step('0, 0, 1, 16'h1280, 0, "R2");

        // R3: pulse source 8, flag remains after the request falls
        step(48'h100, 0, 0, 0, 0, "R3");
        step('0, 0, 0, 0, 0, "R3");
        step('0, 0, 1, 16'h0240, 0, "R3");
        // R4: clear with all-ones data, then zero data on source 9
        step('0, 1, 0, 16'h06C0, 32'hFFFF_FFFF, "R4");
        step('0, 0, 1, 16'h0240, 0, "R4");
        step(48'h200, 0, 0, 0, 0, "R4");
        step('0, 1, 0, 16'h0700, 32'h0, "R4");
        step('0, 0, 1, 16'h0240, 0, "R4");
        // R5: edge on source 9 meets its clear write
        step(48'h200, 1, 0, 16'h0700, 32'h1234, "R5");
        step(48'h200, 0, 1, 16'h0240, 0, "R5");
        step('0, 1, 0, 16'h0700, 0, "R5");
        // R6: level source 5 follows the wire
        step(48'h20, 0, 1, 16'h0240, 0, "R6");
        step('0, 0, 1, 16'h0240, 0, "R6");
        // R8: level fast source 32 alone
        step(48'h1_0000_0000, 0, 1, 16'h2240, 0, "R8");
        step(48'h1_0000_0000, 0, 0, 0, 0, "R8");
        step('0, 0, 0, 0, 0, "R8");
        // R9: writes to undefined and status addresses change nothing
        step('0, 1, 0, 16'h0284, 32'h0, "R9");
        step('0, 1, 0, 16'h1240, 32'hFFFF, "R9");
        step('0, 0, 1, 16'h0280, 0, "R9");
        step('0, 0, 1, 16'h1240, 0, "R9");
        step('0, 0, 1, 16'h0300, 0, "R9");
        // R1: every request high, view all banks
        read_all({48{1'b1}}, "R1");
        // R2: zero disables every source
        for (int b = 0; b < 3; b++)
            step({48{1'b1}}, 1, 0, 16'(16'h0280 + b * 16'h1000), 32'h0, "R2");
        step({48{1'b1}}, 0, 1, 16'h2280, 0, "R2");
        step({48{1'b1}}, 0, 0, 0, 0, "R2");

        // random traffic
        rq = '0;
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            int op = $urandom % 4;
            if ($urandom % 3 == 0) rq = {$urandom, $urandom};
            a = pick_addr($urandom);
            case (op)
                0:       step(rq, 0, 1, a, 0, tag_of(a));
                1:       step(rq, 1, 0, a, $urandom, tag_of(a));
                default: step(rq, 0, 0, 0, 0, "R7");
            endcase
        end

        // R10: reset in the middle of activity
        step({48{1'b1}}, 1, 0, 16'h0280, 32'hFFFF, "R10");
        do_reset();
        read_all('0, "R10");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule